// File: doc/BRIEF.md
# Integer ALU with Signed-Overflow Flag

This is a purely combinational 32-bit arithmetic and logic unit for the execute stage of a simple load/store processor. Two operands and a 4-bit operation code go in. A 32-bit result, a zero flag and an overflow flag come out in the same cycle. The unit covers bitwise AND, OR and NOR, addition, subtraction and a signed set-on-less-than.

A one-bit qualifier tells the unit whether the current add or subtract is the trapping (signed) form or the non-trapping (unsigned) form. Both forms share one adder and give identical result bits. Only the signed form can raise the overflow flag. That flag is a report and nothing more: a separate exception unit decides whether to trap or to suppress the register write.

Signed overflow is found by comparing the carry that enters the sign bit with the carry that leaves it. Set-on-less-than reuses the subtractor and corrects the sign of the difference with that overflow, so the comparison stays right even when the difference wraps. The block has no clock and no handshake. The operands are plain control-path inputs, held for as long as the datapath holds them.

Top module: `int_alu`

## Requirements
- R1: Code 0000 gives the bitwise AND of the operands, code 0001 the bitwise OR, and code 1100 the bitwise NOR.
- R2: Code 0010 gives op_a + op_b and code 0110 gives op_a - op_b, both modulo 2^32.
- R3: With op_signed = 1, add and subtract raise overflow exactly when the carry into bit 31 differs from the carry out of bit 31. On an overflowing add, result bit 31 differs from op_a bit 31.
- R4: With op_signed = 0, add and subtract give the same 32 result bits as with op_signed = 1, and overflow stays 0.
- R5: An add of two operands whose bit 31 differs never overflows. A subtract of two operands whose bit 31 is equal never overflows.
- R6: Code 0111 puts 1 in result bit 0 when op_a < op_b as signed 32-bit numbers, otherwise 0. This holds also when op_a - op_b overflows. Result bits 31..1 are 0.
- R7: zero is 1 exactly when all 32 result bits are 0.
- R8: overflow is 0 for codes 0000, 0001, 1100 and 0111, whatever op_signed is.
- R9: Any code other than 0000, 0001, 0010, 0110, 0111 or 1100 gives result 0 and overflow 0, and therefore zero = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| op_sel | input | 4 | Operation code |
| op_signed | input | 1 | 1 = signed (trapping) add/subtract, 0 = unsigned form |
| result | output | 32 | Operation result |
| zero | output | 1 | Result is all zeros |
| overflow | output | 1 | Signed overflow of add/subtract |

## Verification
The zero flag and the overflow flag can both be set for the same operation. This happens when a signed add wraps to exactly zero, for example 0x80000000 plus itself. The bench includes that vector and checks the result, zero and overflow together against values worked out by hand. A second case uses op_a = 0xFFFFFFFF plus 1: the carry leaves the top bit and zero is set, yet no overflow may appear. Together the two cases show that overflow follows the carries at the sign bit and not the carry out alone.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned ALU_W = 32;
  localparam int unsigned SEL_W = 4;

  localparam logic [SEL_W-1:0] SEL_AND = 4'b0000;
  localparam logic [SEL_W-1:0] SEL_OR  = 4'b0001;
  localparam logic [SEL_W-1:0] SEL_ADD = 4'b0010;
  localparam logic [SEL_W-1:0] SEL_SUB = 4'b0110;
  localparam logic [SEL_W-1:0] SEL_SLT = 4'b0111;
  localparam logic [SEL_W-1:0] SEL_NOR = 4'b1100;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_NOR = 2'd2,
    LG_OFF = 2'd3
  } logic_fn_e;
endpackage

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_pkg::*;
#(
  parameter int unsigned W = ALU_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic_fn_e    fn,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (fn)
      LG_AND:  y = a & b;
      LG_OR:   y = a | b;
      LG_NOR:  y = ~(a | b);
      default: y = '0;
    endcase
  end

  // Each output bit depends only on the same bit of a and b.
  // The check below looks at the topmost bit only.
  always_comb begin
    if (!$isunknown({a, b, fn}) && fn == LG_NOR) begin
      AST_NOR_MSB: assert (y[W-1] == !(a[W-1] || b[W-1])) else $error("nor msb"); // R1
    end
  end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         ovf_raw
);
  localparam int unsigned LW = W - 1;

  logic [W-1:0]  b_eff;
  logic [LW:0]   low_ext;
  logic [1:0]    top_ext;
  logic          c_into_msb;
  logic          c_out_msb;

  assign b_eff = sub ? ~b : b;

  // Lower W-1 bits, with one extra bit to catch the carry into the sign bit.
  assign low_ext    = {1'b0, a[LW-1:0]} + {1'b0, b_eff[LW-1:0]} + {{LW{1'b0}}, sub};
  assign c_into_msb = low_ext[LW];

  // Sign bit, on its own.
  assign top_ext    = {1'b0, a[W-1]} + {1'b0, b_eff[W-1]} + {1'b0, c_into_msb};
  assign c_out_msb  = top_ext[1];

  assign sum     = {top_ext[0], low_ext[LW-1:0]};
  assign ovf_raw = c_into_msb ^ c_out_msb;

  always_comb begin
    if (!$isunknown({a, b, sub}) && (a[W-1] != b_eff[W-1])) begin
      AST_MIXED_SIGN_SAFE: assert (!ovf_raw) else $error("mixed-sign overflow"); // R5
    end
  end
endmodule

// File: rtl/int_alu.sv
module int_alu
  import alu_pkg::*;
#(
  parameter int unsigned W = ALU_W
) (
  input  logic [W-1:0]     op_a,
  input  logic [W-1:0]     op_b,
  input  logic [SEL_W-1:0] op_sel,
  input  logic             op_signed,
  output logic [W-1:0]     result,
  output logic             zero,
  output logic             overflow
);
  logic is_add, is_sub, is_slt, is_logic;
  logic_fn_e   lg_fn;
  logic [W-1:0] lg_y;
  logic [W-1:0] as_sum;
  logic         as_ovf;
  logic         less;

  assign is_add = (op_sel == SEL_ADD);
  assign is_sub = (op_sel == SEL_SUB);
  assign is_slt = (op_sel == SEL_SLT);

  always_comb begin
    unique case (op_sel)
      SEL_AND: lg_fn = LG_AND;
      SEL_OR:  lg_fn = LG_OR;
      SEL_NOR: lg_fn = LG_NOR;
      default: lg_fn = LG_OFF;
    endcase
  end
  assign is_logic = (lg_fn != LG_OFF);

  alu_logic_unit #(.W(W)) u_logic (
    .a  (op_a),
    .b  (op_b),
    .fn (lg_fn),
    .y  (lg_y)
  );

  alu_addsub #(.W(W)) u_addsub (
    .a       (op_a),
    .b       (op_b),
    .sub     (is_sub | is_slt),
    .sum     (as_sum),
    .ovf_raw (as_ovf)
  );

  // The sign of the difference is wrong whenever the subtract overflowed.
  assign less = as_sum[W-1] ^ as_ovf;

  always_comb begin
    if (is_logic)              result = lg_y;
    else if (is_add || is_sub) result = as_sum;
    else if (is_slt)           result = {{(W-1){1'b0}}, less};
    else                       result = '0;
  end

  assign zero     = ~|result;
  assign overflow = as_ovf & op_signed & (is_add | is_sub);

  always_comb begin
    if (!$isunknown({op_a, op_b, op_sel, op_signed})) begin
      if (!op_signed) begin
        AST_UNSIGNED_QUIET: assert (!overflow) else $error("unsigned overflow"); // R4
      end
      if (is_logic || is_slt) begin
        AST_NONARITH_QUIET: assert (!overflow) else $error("non-arith overflow"); // R8
      end
      if (is_slt) begin
        AST_SLT_UPPER_CLEAR: assert (result[W-1:1] == '0) else $error("slt upper bits"); // R6
      end
      if (!is_logic && !is_add && !is_sub && !is_slt) begin
        AST_UNUSED_CODE_IDLE: assert (result == '0 && !overflow && zero) else $error("unused code"); // R9
      end
      if (overflow && is_add) begin
        AST_OVF_SIGN_FLIP: assert (result[W-1] != op_a[W-1]) else $error("overflow sign"); // R3
      end
    end
  end
endmodule

// File: tb/int_alu_bench.sv
module int_alu_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 23;

  typedef struct packed {
    logic [3:0]  sel;
    logic        sgn;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] res;
    logic        ovf;
    logic [3:0]  req;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{4'b0000, 1'b0, 32'hFFFF0000, 32'h0F0F0F0F, 32'h0F0F0000, 1'b0, 4'd1}, // R1 and
    '{4'b0001, 1'b1, 32'hF0000000, 32'h0000000F, 32'hF000000F, 1'b0, 4'd1}, // R1 or
    '{4'b1100, 1'b0, 32'h00FF00FF, 32'h0F000F00, 32'hF000F000, 1'b0, 4'd1}, // R1 nor
    '{4'b0010, 1'b1, 32'h00001234, 32'h00000111, 32'h00001345, 1'b0, 4'd2}, // R2 add
    '{4'b0110, 1'b1, 32'h00000005, 32'h00000007, 32'hFFFFFFFE, 1'b0, 4'd2}, // R2 sub
    '{4'b0010, 1'b1, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1, 4'd3}, // R3
    '{4'b0010, 1'b0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 4'd4}, // R4
    '{4'b0010, 1'b1, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 4'd3}, // R3 zero+ovf
    '{4'b0010, 1'b1, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0, 4'd3}, // R3 carry only
    '{4'b0010, 1'b1, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 1'b0, 4'd5}, // R5
    '{4'b0110, 1'b1, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b1, 4'd3}, // R3
    '{4'b0110, 1'b0, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b0, 4'd4}, // R4
    '{4'b0110, 1'b1, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 1'b1, 4'd3}, // R3
    '{4'b0110, 1'b1, 32'h7FFFFFFF, 32'h00000001, 32'h7FFFFFFE, 1'b0, 4'd5}, // R5
    '{4'b0110, 1'b1, 32'h80000000, 32'hFFFFFFFF, 32'h80000001, 1'b0, 4'd5}, // R5
    '{4'b0111, 1'b1, 32'hFFFFFFFB, 32'h00000003, 32'h00000001, 1'b0, 4'd6}, // R6
    '{4'b0111, 1'b1, 32'h00000003, 32'hFFFFFFFB, 32'h00000000, 1'b0, 4'd6}, // R6
    '{4'b0111, 1'b1, 32'h80000000, 32'h00000001, 32'h00000001, 1'b0, 4'd6}, // R6 wrap
    '{4'b0111, 1'b1, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b0, 4'd6}, // R6 wrap
    '{4'b0111, 1'b0, 32'h80000000, 32'h00000001, 32'h00000001, 1'b0, 4'd8}, // R8
    '{4'b0110, 1'b1, 32'h12345678, 32'h12345678, 32'h00000000, 1'b0, 4'd7}, // R7
    '{4'b0011, 1'b1, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0, 4'd9}, // R9
    '{4'b1111, 1'b1, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h00000000, 1'b0, 4'd9}  // R9
  };

  logic        clk = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [3:0]  op_sel = '0;
  logic        op_signed = 1'b0;
  logic [31:0] result;
  logic        zero;
  logic        overflow;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  int_alu u_int_alu (
    .op_a      (op_a),
    .op_b      (op_b),
    .op_sel    (op_sel),
    .op_signed (op_signed),
    .result    (result),
    .zero      (zero),
    .overflow  (overflow)
  );

  task automatic apply(input logic [3:0] s, input logic g, input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    op_sel = s; op_signed = g; op_a = a; op_b = b;
    @(posedge clk);
    #1;
  endtask

  task automatic check(input int rq, input logic [31:0] er, input logic eo);
    total++;
    if (result !== er || overflow !== eo || zero !== (er == 32'h0)) begin
      bad++;
      $display("FAIL R%0d: res=%h ovf=%b zero=%b expected res=%h ovf=%b zero=%b",
               rq, result, overflow, zero, er, eo, (er == 32'h0));
    end
  endtask

  initial begin
    // Idle inputs: AND of zeros gives zero result with zero set (R7)
    #(CLK_PERIOD + 1);
    check(7, 32'h0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].sel, VECS[i].sgn, VECS[i].a, VECS[i].b);
      check(int'(VECS[i].req), VECS[i].res, VECS[i].ovf);
    end

    // R8 and R9 sweep: every code with operands that overflow on add
    for (int c = 0; c < 16; c++) begin
      logic [31:0] er;
      case (c)
        0:  er = 32'h00000001;
        1:  er = 32'h7FFFFFFF;
        2:  er = 32'h80000000;
        6:  er = 32'h7FFFFFFE;
        7:  er = 32'h00000000;
        12: er = 32'h80000000;
        default: er = 32'h0;
      endcase
      apply(c[3:0], 1'b1, 32'h7FFFFFFF, 32'h00000001);
      check((c == 2) ? 3 : 8, er, (c == 2));
    end

    // R4: unsigned form matches the signed result bits for a wrapping subtract
    apply(4'b0110, 1'b0, 32'h7FFFFFFF, 32'hFFFFFFFF);
    check(4, 32'h80000000, 1'b0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule